// File: doc/BRIEF.md
# Halfword Load Decode-Execute Unit

This unit executes exactly one zero-extending halfword load. It accepts one fetched instruction at a time, from either the fixed-length 32-bit instruction set or the compact set. A compact instruction is either one 16-bit halfword or a 32-bit halfword pair, and its first halfword always sits in bits 31:16 of the instruction word. The unit decodes every halfword-load form: immediate offset, pre-indexed, post-indexed, PC-relative literal and register offset. It reads the base and index registers through two combinational register-file read ports and forms the effective address.

It then issues one 2-byte read on a valid/ready memory port and waits for a single response. Through one register write port it writes an optional base-register update first and then the zero-extended data to the target register. A `done` pulse retires every instruction. `done_fault` marks an odd access address and `done_undef` marks an encoding that is not recognised. Condition flags arrive as an input and are only read, never produced.

Top module: `hld_unit`

## Requirements
- R1: Compact wide form: the upper twelve instruction bits equal 0xF8B, Rn is bits 19:16, Rt is bits 15:12 and the unsigned offset is bits 11:0. The access address is Rn plus the offset, there is no base update, and exactly one register write of the loaded data goes to Rt.
- R2: Compact 16-bit forms, held in bits 31:16 of the word (Rt is bits 2:0, Rn is bits 5:3, Rm is bits 8:6 of that halfword). In pattern `10001` + imm5 the address is Rn + imm5×2. In pattern `0101101` the address is Rn + Rm. Neither form updates the base.
- R3: Compact 8-bit forms: the upper twelve bits equal 0xF83, bit 11 is 1, bits 10/9/8 are index/add/update and bits 7:0 are the offset. `100` accesses Rn−imm8 with no update. Index 0 with update 1 accesses Rn and then writes Rn±imm8 back. Index 1 with update 1 accesses Rn±imm8 and writes that value back.
- R4: Fixed-set immediate form. Fields: condition 31:28, bits 27:25 = 000, P = 24, U = 23, bit 22 = 1, W = 21, bit 20 = 1, Rn = 19:16, Rt = 15:12, bits 7:4 = 1011. The offset is {bits 11:8, bits 3:0}. U=1 adds and U=0 subtracts. P=1 accesses the offset address and P=0 accesses the plain base. The base is updated when P=0 or W=1.
- R5: Fixed-set register form: same layout with bit 22 = 0, bits 11:8 = 0 and Rm in bits 3:0. U selects Rn+Rm or Rn−Rm, and P and W behave as in R4.
- R6: A base field of 15 selects a literal load from the word-aligned PC, with no base update. The compact literal form takes its add flag from bit 23 and a 12-bit offset. The fixed literal form takes the R4 offset and U.
- R7: The 16-bit response is written to Rt zero-extended: bits 31:16 of the write data are 0.
- R8: With a base update, the base write comes first and the Rt write comes in the next cycle. When Rn equals Rt, that register ends holding the loaded data.
- R9: An odd access address retires the instruction with `done_fault`=1, no memory request and no register write.
- R10: A fixed-set condition that fails against `instr_nzcv` ({N,Z,C,V} in bits 3:0) retires the instruction with no memory request and no register write. Condition 0000 requires Z=1, 1010 requires N=V, and 1110 always passes.
- R11: An encoding that matches no listed form retires with `done_undef`=1, no memory request and no register write. This covers compact 8-bit pattern `1110`, fixed condition 1111 and unrecognised 16-bit halfwords.
- R12: `instr_ready` is 1 only while the unit is idle. A memory request keeps its valid and address stable until `mem_req_ready`, and each instruction issues at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle and accepting |
| instr_compact | input | 1 | 1 = compact set, 0 = fixed-length set |
| instr_word | input | 32 | Instruction; compact first halfword in bits 31:16 |
| instr_pc | input | XLEN | PC value used by literal forms |
| instr_nzcv | input | 4 | Flags {N,Z,C,V} for the condition test |
| rf_rd_base_addr | output | RA_W | Base register read index |
| rf_rd_base_data | input | XLEN | Base register value (same cycle) |
| rf_rd_idx_addr | output | RA_W | Index register read index |
| rf_rd_idx_data | input | XLEN | Index register value (same cycle) |
| mem_req_valid | output | 1 | Halfword read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Byte address of the halfword |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | HALF_W | Returned halfword |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RA_W | Register write index |
| rf_wdata | output | XLEN | Register write value |
| done | output | 1 | Instruction retired this cycle |
| done_fault | output | 1 | Retired on a misaligned address |
| done_undef | output | 1 | Retired on an unrecognised encoding |

## Verification
The checker takes for granted that memory answers each accepted request with exactly one response, never sends one unrequested, and asserts `mem_req_ready` only while a request is pending. It also assumes register reads return data combinationally in the cycle the index is presented. The bench's memory model raises ready only against a visible request, optionally after a programmed number of stall cycles, and returns the data one cycle after the handshake. Its register model is a plain array read through continuous assignments, and each instruction is offered only while `instr_ready` is high.

// File: rtl/hld_pkg.sv
package hld_pkg;
  localparam int XLEN_D   = 32;
  localparam int HALF_W_D = 16;
  localparam int RA_W_D   = 4;
  localparam int IMM_W    = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_REQ, ST_WAIT, ST_WB, ST_RT
  } st_e;

  typedef struct packed {
    logic             legal;
    logic [3:0]       cond;
    logic             use_rm;
    logic             use_pc;
    logic [3:0]       rn;
    logic [3:0]       rm;
    logic [3:0]       rt;
    logic [IMM_W-1:0] imm;
    logic             add;
    logic             index;
    logic             wback;
  } dec_t;
endpackage

// File: rtl/hld_decode.sv
module hld_decode
  import hld_pkg::*;
(
  input  logic        is_compact,
  input  logic [31:0] iw,
  output dec_t        d
);
  logic [15:0] h;
  logic        pair32;
  logic        fx_ok;

  always_comb begin
    h      = iw[31:16];
    pair32 = (iw[31:29] == 3'b111) && (iw[28:27] != 2'b00);
    fx_ok  = 1'b0;
    d      = '0;
    d.cond = 4'hE;
    if (!is_compact) begin
      d.cond  = iw[31:28];
      d.rn    = iw[19:16];
      d.rt    = iw[15:12];
      d.index = iw[24];
      d.add   = iw[23];
      d.wback = !iw[24] || iw[21];
      fx_ok   = (iw[27:25] == 3'b000) && iw[20] && (iw[7:4] == 4'b1011) &&
                (iw[31:28] != 4'hF) && !(!iw[24] && iw[21]);
      if (iw[22]) begin
        d.imm = {4'h0, iw[11:8], iw[3:0]};
        if (iw[19:16] == 4'hF) begin
          d.use_pc = 1'b1;
          d.wback  = 1'b0;
          d.legal  = fx_ok && iw[24] && !iw[21];
        end else begin
          d.legal  = fx_ok;
        end
      end else begin
        d.use_rm = 1'b1;
        d.rm     = iw[3:0];
        d.legal  = fx_ok && (iw[11:8] == 4'h0) && (iw[19:16] != 4'hF);
      end
    end else if (pair32) begin
      d.rn = iw[19:16];
      d.rt = iw[15:12];
      if ((iw[31:24] == 8'hF8) && (iw[22:20] == 3'b011) && (iw[19:16] == 4'hF)) begin
        d.use_pc = 1'b1;
        d.add    = iw[23];
        d.index  = 1'b1;
        d.imm    = iw[11:0];
        d.legal  = 1'b1;
      end else if (iw[31:20] == 12'hF8B) begin
        d.add    = 1'b1;
        d.index  = 1'b1;
        d.imm    = iw[11:0];
        d.legal  = 1'b1;
      end else if ((iw[31:20] == 12'hF83) && iw[11]) begin
        d.imm    = {4'h0, iw[7:0]};
        d.index  = iw[10];
        d.add    = iw[9];
        d.wback  = iw[8];
        d.legal  = iw[8] || (iw[10:8] == 3'b100);
      end
    end else begin
      d.rt    = {1'b0, h[2:0]};
      d.rn    = {1'b0, h[5:3]};
      d.index = 1'b1;
      d.add   = 1'b1;
      if (h[15:11] == 5'b10001) begin
        d.imm   = {6'h0, h[10:6], 1'b0};
        d.legal = 1'b1;
      end else if (h[15:9] == 7'b0101101) begin
        d.use_rm = 1'b1;
        d.rm     = {1'b0, h[8:6]};
        d.legal  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hld_cond.sv
module hld_cond (
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;

  always_comb begin
    {n, z, c, v} = nzcv;
    unique case (cond)
      4'h0:    pass = z;
      4'h1:    pass = !z;
      4'h2:    pass = c;
      4'h3:    pass = !c;
      4'h4:    pass = n;
      4'h5:    pass = !n;
      4'h6:    pass = v;
      4'h7:    pass = !v;
      4'h8:    pass = c && !z;
      4'h9:    pass = !c || z;
      4'hA:    pass = (n == v);
      4'hB:    pass = (n != v);
      4'hC:    pass = !z && (n == v);
      4'hD:    pass = z || (n != v);
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/hld_agen.sv
module hld_agen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic             use_pc,
  input  logic             use_rm,
  input  logic             add,
  input  logic             index,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  base_data,
  input  logic [XLEN-1:0]  idx_data,
  output logic [XLEN-1:0]  acc_addr,
  output logic [XLEN-1:0]  off_addr
);
  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  always_comb begin
    base     = use_pc ? (pc & WORD_MASK) : base_data;
    offs     = use_rm ? idx_data : XLEN'(imm);
    off_addr = add ? (base + offs) : (base - offs);
    acc_addr = index ? off_addr : base;
  end
endmodule

// File: rtl/hld_unit.sv
module hld_unit
  import hld_pkg::*;
#(
  parameter int XLEN   = XLEN_D,
  parameter int HALF_W = HALF_W_D,
  parameter int RA_W   = RA_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic              instr_compact,
  input  logic [31:0]       instr_word,
  input  logic [XLEN-1:0]   instr_pc,
  input  logic [3:0]        instr_nzcv,
  output logic [RA_W-1:0]   rf_rd_base_addr,
  input  logic [XLEN-1:0]   rf_rd_base_data,
  output logic [RA_W-1:0]   rf_rd_idx_addr,
  input  logic [XLEN-1:0]   rf_rd_idx_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [HALF_W-1:0] mem_rsp_data,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              done,
  output logic              done_fault,
  output logic              done_undef
);
  logic [1:0]        rsync_q;
  logic              rst_sync_n;
  st_e               st_q, st_d;
  logic [31:0]       iw_q;
  logic              cmp_q;
  logic [XLEN-1:0]   pc_q;
  logic [3:0]        nzcv_q;
  logic [XLEN-1:0]   addr_q, wbv_q;
  logic [3:0]        rn_q, rt_q;
  logic              wb_q;
  logic [HALF_W-1:0] data_q;

  dec_t              dec;
  logic              cond_ok;
  logic [XLEN-1:0]   acc_addr, off_addr;
  logic              accept, exec_go, exec_stop, rsp_take;

  hld_decode u_dec (
    .is_compact (cmp_q),
    .iw         (iw_q),
    .d          (dec)
  );

  hld_cond u_cond (
    .cond (dec.cond),
    .nzcv (nzcv_q),
    .pass (cond_ok)
  );

  hld_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .use_pc    (dec.use_pc),
    .use_rm    (dec.use_rm),
    .add       (dec.add),
    .index     (dec.index),
    .imm       (dec.imm),
    .pc        (pc_q),
    .base_data (rf_rd_base_data),
    .idx_data  (rf_rd_idx_data),
    .acc_addr  (acc_addr),
    .off_addr  (off_addr)
  );

  // reset: asynchronous assertion, synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // enables
  always_comb begin
    accept    = (st_q == ST_IDLE) && instr_valid;
    exec_go   = (st_q == ST_EXEC) && dec.legal && cond_ok && !acc_addr[0];
    exec_stop = (st_q == ST_EXEC) && !exec_go;
    rsp_take  = (st_q == ST_WAIT) && mem_rsp_valid;
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)        st_d = ST_EXEC;
      ST_EXEC: st_d = exec_go ? ST_REQ : ST_IDLE;
      ST_REQ:  if (mem_req_ready) st_d = ST_WAIT;
      ST_WAIT: if (rsp_take)      st_d = wb_q ? ST_WB : ST_RT;
      ST_WB:   st_d = ST_RT;
      ST_RT:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  // datapath registers, written under explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      iw_q   <= instr_word;
      cmp_q  <= instr_compact;
      pc_q   <= instr_pc;
      nzcv_q <= instr_nzcv;
    end
    if (exec_go) begin
      addr_q <= acc_addr;
      wbv_q  <= off_addr;
      rn_q   <= dec.rn;
      rt_q   <= dec.rt;
      wb_q   <= dec.wback;
    end
    if (rsp_take) begin
      data_q <= mem_rsp_data;
    end
  end

  // outputs
  always_comb begin
    instr_ready     = (st_q == ST_IDLE);
    rf_rd_base_addr = RA_W'(dec.rn);
    rf_rd_idx_addr  = RA_W'(dec.rm);
    mem_req_valid   = (st_q == ST_REQ);
    mem_req_addr    = addr_q;
    rf_we           = (st_q == ST_WB) || (st_q == ST_RT);
    rf_waddr        = (st_q == ST_WB) ? RA_W'(rn_q) : RA_W'(rt_q);
    rf_wdata        = (st_q == ST_WB) ? wbv_q : XLEN'(data_q);
    done            = exec_stop || (st_q == ST_RT);
    done_undef      = exec_stop && !dec.legal;
    done_fault      = exec_stop && dec.legal && cond_ok;
  end
endmodule

// File: rtl/hld_unit_chk.sv
module hld_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            rf_we,
  input logic            done,
  input logic            done_fault,
  input logic            done_undef
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (!mem_req_valid && !rf_we && !done));

  assert_idle_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> instr_ready);

  assert_req_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_req_addr[0]);

  assert_fault_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (!rf_we && !mem_req_valid));

  assert_undef_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_undef) |-> (!rf_we && !mem_req_valid && !done_fault));

  assert_rt_after_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !done) |=> (rf_we && done));
endmodule

bind hld_unit hld_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_ready   (instr_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rf_we         (rf_we),
  .done          (done),
  .done_fault    (done_fault),
  .done_undef    (done_undef)
);

// File: tb/hld_unit_tb_top.sv
`timescale 1ns/1ps
module hld_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic        instr_compact = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] instr_pc = '0;
  logic [3:0]  instr_nzcv = '0;
  logic [3:0]  rf_rd_base_addr, rf_rd_idx_addr;
  logic [31:0] rf_rd_base_data, rf_rd_idx_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        done, done_fault, done_undef;

  logic [31:0] reg_m [16];
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // per-run logs
  int          req_cnt, wr_cnt, done_cnt, stab_err, busy_err, stall_left;
  logic [31:0] req_addr;
  logic [3:0]  wr_a [4];
  logic [31:0] wr_d [4];
  logic        got_fault, got_undef, busy;
  logic        given, pend;
  logic [31:0] pend_addr, hs_addr;

  always #2.5 clk = ~clk;

  assign rf_rd_base_data = reg_m[rf_rd_base_addr];
  assign rf_rd_idx_data  = reg_m[rf_rd_idx_addr];

  hld_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_compact(instr_compact), .instr_word(instr_word),
    .instr_pc(instr_pc), .instr_nzcv(instr_nzcv),
    .rf_rd_base_addr(rf_rd_base_addr), .rf_rd_base_data(rf_rd_base_data),
    .rf_rd_idx_addr(rf_rd_idx_addr), .rf_rd_idx_data(rf_rd_idx_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .done_fault(done_fault),
    .done_undef(done_undef)
  );

  function automatic logic [15:0] memdata(input logic [31:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  function automatic logic [31:0] fx(input logic [3:0] cnd, input logic p, u, i, w,
                                     input logic [3:0] rn, rt, hi, lo);
    return {cnd, 3'b000, p, u, i, w, 1'b1, rn, rt, hi, 4'b1011, lo};
  endfunction

  function automatic logic [31:0] c8(input logic [3:0] rn, rt, input logic p, u, w,
                                     input logic [7:0] imm);
    return {12'hF83, rn, rt, 1'b1, p, u, w, imm};
  endfunction

  // memory responder and port monitor, all at the falling edge
  initial begin
    given = 1'b0; pend = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (given) begin
        given = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = memdata(hs_addr);
      end else if (mem_req_valid) begin
        if (!pend) begin pend = 1'b1; pend_addr = mem_req_addr; end
        else if (mem_req_addr != pend_addr) stab_err++;
        if (stall_left > 0) stall_left--;
        else begin
          mem_req_ready = 1'b1; given = 1'b1; pend = 1'b0;
          hs_addr = mem_req_addr;
          if (req_cnt == 0) req_addr = mem_req_addr;
          req_cnt++;
        end
      end
      if (rf_we) begin
        if (wr_cnt < 4) begin wr_a[wr_cnt] = rf_waddr; wr_d[wr_cnt] = rf_wdata; end
        wr_cnt++;
        reg_m[rf_waddr] = rf_wdata;
      end
      if (done) begin done_cnt++; got_fault = done_fault; got_undef = done_undef; end
      if (busy && instr_ready) busy_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic cmp, input logic [31:0] w, input logic [31:0] pc,
                     input logic [3:0] f, input int stall);
    int n;
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!instr_ready && n < 50);
    req_cnt = 0; wr_cnt = 0; done_cnt = 0; stab_err = 0; busy_err = 0;
    got_fault = 1'b0; got_undef = 1'b0; stall_left = stall; req_addr = 'x;
    instr_compact = cmp; instr_word = w; instr_pc = pc; instr_nzcv = f;
    instr_valid = 1'b1;
    @(negedge clk); #1;
    instr_valid = 1'b0;
    busy = 1'b1;
    n = 0;
    while (done_cnt == 0 && n < 60) begin @(negedge clk); #1; n++; end
    busy = 1'b0;
    chk(done_cnt == 1, "R12", "retire count", done_cnt, 1);
    chk(busy_err == 0 && stab_err == 0, "R12", "ready/stability errors",
        busy_err + stab_err, 0);
  endtask

  // a load that must access addr and write rt, optionally after base update
  task automatic expect_load(input string req, input logic [31:0] addr,
                             input bit wb, input logic [3:0] rn, input logic [31:0] wbv,
                             input logic [3:0] rt);
    logic [31:0] d;
    d = {16'h0, memdata(addr)};
    chk(req_cnt == 1, req, "request count", req_cnt, 1);
    chk(req_addr == addr, req, "access address", req_addr, addr);
    chk(wr_cnt == (wb ? 2 : 1), req, "write count", wr_cnt, wb ? 2 : 1);
    chk(!got_fault && !got_undef, req, "status", {got_fault, got_undef}, 0);
    if (wb) begin
      chk(wr_a[0] == rn && wr_d[0] == wbv, req, "base update", wr_d[0], wbv);
      chk(wr_a[1] == rt && wr_d[1] == d, req, "data write after base", wr_d[1], d);
    end else begin
      chk(wr_a[0] == rt && wr_d[0] == d, req, "data write", wr_d[0], d);
    end
  endtask

  task automatic expect_silent(input string req, input bit fault, input bit undef);
    chk(req_cnt == 0, req, "no request", req_cnt, 0);
    chk(wr_cnt == 0, req, "no register write", wr_cnt, 0);
    chk(got_fault == fault && got_undef == undef, req, "retire status",
        {got_fault, got_undef}, {fault, undef});
  endtask

  task automatic t_reset;
    chk(instr_ready === 1'b1, "R12", "ready after reset", instr_ready, 1);
    chk(mem_req_valid === 1'b0 && rf_we === 1'b0 && done === 1'b0, "R12",
        "quiet after reset", {mem_req_valid, rf_we, done}, 0);
  endtask

  task automatic t_wide_R1_R7;
    reg_m[1] = 32'h1000;
    run(1'b1, {12'hF8B, 4'd1, 4'd3, 12'd16}, 0, 4'h0, 0);
    expect_load("R1", 32'h1010, 0, 0, 0, 4'd3);
    chk(wr_d[0][31:16] == 16'h0 && wr_d[0][15], "R7", "zero-extension",
        wr_d[0], {16'h0, memdata(32'h1010)});
  endtask

  task automatic t_short_R2;
    reg_m[2] = 32'h2000; reg_m[5] = 32'h22;
    run(1'b1, {5'b10001, 5'd5, 3'd2, 3'd4, 16'h0}, 0, 4'h0, 0);
    expect_load("R2", 32'h200A, 0, 0, 0, 4'd4);
    run(1'b1, {7'b0101101, 3'd5, 3'd2, 3'd6, 16'h0}, 0, 4'h0, 0);
    expect_load("R2", 32'h2022, 0, 0, 0, 4'd6);
  endtask

  task automatic t_imm8_R3_R8;
    reg_m[1] = 32'h1000;
    run(1'b1, c8(4'd1, 4'd7, 1'b1, 1'b0, 1'b0, 8'h20), 0, 4'h0, 0);
    expect_load("R3", 32'h0FE0, 0, 0, 0, 4'd7);
    reg_m[8] = 32'h3000;
    run(1'b1, c8(4'd8, 4'd9, 1'b0, 1'b1, 1'b1, 8'h06), 0, 4'h0, 0);
    expect_load("R3", 32'h3000, 1, 4'd8, 32'h3006, 4'd9);
    reg_m[10] = 32'h4000;
    run(1'b1, c8(4'd10, 4'd10, 1'b1, 1'b0, 1'b1, 8'h04), 0, 4'h0, 0);
    expect_load("R8", 32'h3FFC, 1, 4'd10, 32'h3FFC, 4'd10);
    chk(reg_m[10] == {16'h0, memdata(32'h3FFC)}, "R8", "Rn==Rt final value",
        reg_m[10], {16'h0, memdata(32'h3FFC)});
  endtask

  task automatic t_undef_R11;
    run(1'b1, c8(4'd1, 4'd2, 1'b1, 1'b1, 1'b0, 8'h02), 0, 4'h0, 0);
    expect_silent("R11", 0, 1);
    run(1'b1, 32'hBF00_0000, 0, 4'h0, 0);
    expect_silent("R11", 0, 1);
    run(1'b0, fx(4'hF, 1, 1, 1, 0, 4'd1, 4'd2, 4'h0, 4'h2), 0, 4'h0, 0);
    expect_silent("R11", 0, 1);
  endtask

  task automatic t_fixed_R4;
    reg_m[1] = 32'h1000;
    run(1'b0, fx(4'hE, 1, 1, 1, 0, 4'd1, 4'd11, 4'h3, 4'hA), 0, 4'h0, 0);
    expect_load("R4", 32'h103A, 0, 0, 0, 4'd11);
    reg_m[12] = 32'h5000;
    run(1'b0, fx(4'hE, 0, 0, 1, 0, 4'd12, 4'd13, 4'h1, 4'h2), 0, 4'h0, 0);
    expect_load("R4", 32'h5000, 1, 4'd12, 32'h4FEE, 4'd13);
  endtask

  task automatic t_fixed_reg_R5;
    reg_m[1] = 32'h1000; reg_m[2] = 32'h2000; reg_m[5] = 32'h22;
    run(1'b0, fx(4'hE, 1, 0, 0, 0, 4'd1, 4'd14, 4'h0, 4'd5), 0, 4'h0, 0);
    expect_load("R5", 32'h0FDE, 0, 0, 0, 4'd14);
    run(1'b0, fx(4'hE, 1, 1, 0, 1, 4'd2, 4'd3, 4'h0, 4'd5), 0, 4'h0, 0);
    expect_load("R5", 32'h2022, 1, 4'd2, 32'h2022, 4'd3);
  endtask

  task automatic t_literal_R6;
    run(1'b1, {12'hF8B, 4'hF, 4'd4, 12'h020}, 32'h8006, 4'h0, 0);
    expect_load("R6", 32'h8024, 0, 0, 0, 4'd4);
    run(1'b1, {12'hF83, 4'hF, 4'd4, 12'h010}, 32'h8006, 4'h0, 0);
    expect_load("R6", 32'h7FF4, 0, 0, 0, 4'd4);
    run(1'b0, fx(4'hE, 1, 1, 1, 0, 4'hF, 4'd5, 4'h0, 4'h8), 32'h9003, 4'h0, 0);
    expect_load("R6", 32'h9008, 0, 0, 0, 4'd5);
  endtask

  task automatic t_misalign_R9;
    reg_m[1] = 32'h1000;
    run(1'b1, {12'hF8B, 4'd1, 4'd3, 12'h011}, 0, 4'h0, 0);
    expect_silent("R9", 1, 0);
    reg_m[12] = 32'h5001;
    run(1'b0, fx(4'hE, 0, 1, 1, 0, 4'd12, 4'd13, 4'h0, 4'h2), 0, 4'h0, 0);
    expect_silent("R9", 1, 0);
    chk(reg_m[12] == 32'h5001, "R9", "base untouched", reg_m[12], 32'h5001);
  endtask

  task automatic t_cond_R10;
    reg_m[1] = 32'h1000;
    run(1'b0, fx(4'h0, 1, 1, 1, 0, 4'd1, 4'd6, 4'h0, 4'h4), 0, 4'b0000, 0);
    expect_silent("R10", 0, 0);
    run(1'b0, fx(4'h0, 1, 1, 1, 0, 4'd1, 4'd6, 4'h0, 4'h4), 0, 4'b0100, 0);
    expect_load("R10", 32'h1004, 0, 0, 0, 4'd6);
    run(1'b0, fx(4'hA, 1, 1, 1, 0, 4'd1, 4'd6, 4'h0, 4'h6), 0, 4'b1000, 0);
    expect_silent("R10", 0, 0);
    run(1'b0, fx(4'hE, 1, 1, 1, 0, 4'd1, 4'd6, 4'h0, 4'h6), 0, 4'b1111, 0);
    expect_load("R10", 32'h1006, 0, 0, 0, 4'd6);
  endtask

  task automatic t_stall_R12;
    reg_m[1] = 32'h1000;
    run(1'b1, {12'hF8B, 4'd1, 4'd2, 12'h0A2}, 0, 4'h0, 3);
    expect_load("R12", 32'h10A2, 0, 0, 0, 4'd2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) reg_m[i] = 32'h0;
    busy = 1'b0; stall_left = 0; req_cnt = 0; wr_cnt = 0; done_cnt = 0;
    stab_err = 0; busy_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_wide_R1_R7();
    t_short_R2();
    t_imm8_R3_R8();
    t_undef_R11();
    t_fixed_R4();
    t_fixed_reg_R5();
    t_literal_R6();
    t_misalign_R9();
    t_cond_R10();
    t_stall_R12();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule